// File: doc/BRIEF.md
# Parallel Per-Slot Header Action Unit

This block is one action stage in a chain of match/action stages. A header vector arrives split into equal-width field slots. Each slot has its own small ALU, and all of them work at the same time. They are steered by one wide instruction word held in a small instruction memory. The match result picks the word. On a hit, the action index that comes with the header addresses the memory. On a miss, a default index supplied on a port is used instead. Each slot gets its own opcode, a source-slot selector and an immediate-lane selector. The immediate values come from the action-data vector that travels with the match result.

One extra bit in the word marks the packet for dropping. This carries the deny outcome next to the rewritten header. The unit accepts a header on every clock. It returns the result exactly two cycles later: one cycle to fetch the instruction, one cycle to execute. Instruction words are loaded through a simple write port.

Top module: `vliw_action_unit`

## Requirements
- R1: A header accepted with `in_valid` high appears with `out_valid` high exactly two clock edges later. Back-to-back inputs give back-to-back outputs, and cycles without `in_valid` give `out_valid` low.
- R2: On `in_hit` high, the instruction word is read at `in_act_idx`. On `in_hit` low, it is read at `dflt_idx`.
- R3: With `cfg_we` high, `cfg_word` is stored at `cfg_addr`. The new word applies to headers presented in later cycles. A header presented in the same cycle as the write still uses the previous word. Reset clears every word to zero, which means all no-op and no drop.
- R4: Instruction layout, with NS slots and SW = log2(NS). Slot i owns bits [i*SF +: SF], where SF = 3 + 2*SW. Inside that field, the upper 3 bits are the opcode, the next SW bits are the source slot, and the low SW bits are the immediate lane. Bit NS*SF is the drop bit.
- R5: Opcode 0 (no-op) and opcode 7 (reserved) leave the slot unchanged.
- R6: Opcode 1 writes the slot with the selected action-data lane, where lane k is `in_act_data[k*W +: W]`.
- R7: Opcode 2 copies the selected source slot of the incoming, pre-action header. It never sees another slot's new value.
- R8: Opcode 3 adds the selected lane and opcode 4 subtracts it, both wrapping modulo 2^W.
- R9: Opcode 5 takes the bitwise AND with the selected lane, and opcode 6 takes the bitwise OR.
- R10: `out_drop` equals the drop bit of the word used for that header, and it is high only while `out_valid` is high.
- R11: While `rst` is high, `out_valid` and `out_drop` read low at the next edge and stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present this cycle |
| in_hdr | input | NS*W | Incoming header vector, slot i at [i*W +: W] |
| in_hit | input | 1 | Match hit flag |
| in_act_idx | input | AW | Action index from the match |
| in_act_data | input | NS*W | Immediate lanes for this header |
| dflt_idx | input | AW | Instruction index used on a miss |
| cfg_we | input | 1 | Instruction memory write strobe |
| cfg_addr | input | AW | Instruction memory write address |
| cfg_word | input | NS*SF+1 | Instruction word to store |
| out_valid | output | 1 | Result header present |
| out_hdr | output | NS*W | Modified header vector |
| out_drop | output | 1 | Deny flag for the result header |

## Verification
The bench sweeps every opcode against every source and lane selector, with the selectors rotated per slot. Each combination runs on varied data. All-ones and all-zero headers are included so that add and subtract must wrap. A design with an off-by-one field position, or with a swapped source and lane selector, then gives wrong bytes.

Misses steer the fetch to the default index while the action index points elsewhere. This catches a design that ignores the hit flag. Copies are mixed with arithmetic in the same word. A design that chains partly updated slots then reads new values instead of the incoming ones.

A write to the memory in the same cycle that a header reads the same entry must return the old word. The bench also checks that reset leaves every entry as a pass-through with no drop.

// File: rtl/vliw_act_pkg.sv
package vliw_act_pkg;

    // Per-slot operation codes; values are part of the instruction format.
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_SET  = 3'd1,
        OP_COPY = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_AND  = 3'd5,
        OP_OR   = 3'd6,
        OP_RSV  = 3'd7
    } slot_op_e;

    localparam int OP_W = 3;

    // Selector width for a given slot count (at least one bit).
    function automatic int sel_width(input int slots);
        return (slots > 1) ? $clog2(slots) : 1;
    endfunction

    // Width of one slot's control field.
    function automatic int field_width(input int slots);
        return OP_W + 2 * sel_width(slots);
    endfunction

endpackage

// File: rtl/vliw_imem.sv
module vliw_imem #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int IW    = 29
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);

    logic [IW-1:0] mem [DEPTH];

    // Registered read; a same-cycle write is seen only by later reads.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
            if (we) begin
                mem[waddr] <= wdata;
            end
        end
    end

    // R3: a written word is held at its address on the following cycle
    assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/vliw_operand_sel.sv
module vliw_operand_sel #(
    parameter int NS = 4,
    parameter int W  = 8,
    parameter int SW = 2
) (
    input  logic [NS*W-1:0] hdr_vec,
    input  logic [NS*W-1:0] imm_vec,
    input  logic [SW-1:0]   src_sel,
    input  logic [SW-1:0]   imm_sel,
    output logic [W-1:0]    src_val,
    output logic [W-1:0]    imm_val
);

    // Sources always come from the pre-action vector.
    always_comb begin
        src_val = hdr_vec[src_sel*W +: W];
        imm_val = imm_vec[imm_sel*W +: W];
    end

endmodule

// File: rtl/vliw_slot_alu.sv
module vliw_slot_alu
    import vliw_act_pkg::*;
#(
    parameter int W = 8
) (
    input  slot_op_e     op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] src_val,
    input  logic [W-1:0] imm_val,
    output logic [W-1:0] res
);

    always_comb begin
        case (op)
            OP_SET:  res = imm_val;
            OP_COPY: res = src_val;
            OP_ADD:  res = cur + imm_val;
            OP_SUB:  res = cur - imm_val;
            OP_AND:  res = cur & imm_val;
            OP_OR:   res = cur | imm_val;
            default: res = cur;
        endcase
    end

endmodule

// File: rtl/vliw_action_unit.sv
module vliw_action_unit
    import vliw_act_pkg::*;
#(
    parameter int NS    = 4,
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int SW    = sel_width(NS),
    parameter int SF    = field_width(NS),
    parameter int IW    = NS * SF + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [NS*W-1:0] in_hdr,
    input  logic            in_hit,
    input  logic [AW-1:0]   in_act_idx,
    input  logic [NS*W-1:0] in_act_data,
    input  logic [AW-1:0]   dflt_idx,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [IW-1:0]   cfg_word,
    output logic            out_valid,
    output logic [NS*W-1:0] out_hdr,
    output logic            out_drop
);

    localparam int HW       = NS * W;
    localparam int DROP_BIT = IW - 1;

    typedef struct packed {
        slot_op_e      op;
        logic [SW-1:0] src;
        logic [SW-1:0] isel;
    } slot_ctl_t;

    // ---------------- stage 1: instruction fetch ----------------
    logic [AW-1:0] fetch_idx;
    logic [IW-1:0] inst_q;
    logic          s1_valid;
    logic [HW-1:0] s1_hdr;
    logic [HW-1:0] s1_imm;

    assign fetch_idx = in_hit ? in_act_idx : dflt_idx;

    vliw_imem #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .IW    (IW)
    ) u_imem (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_word),
        .raddr (fetch_idx),
        .rdata (inst_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hdr   <= '0;
            s1_imm   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_hdr   <= in_hdr;
            s1_imm   <= in_act_data;
        end
    end

    // ---------------- stage 2: execute ----------------
    slot_ctl_t     ctl [NS];
    logic [HW-1:0] exec_hdr;

    for (genvar i = 0; i < NS; i++) begin : g_slot
        logic [W-1:0] src_val;
        logic [W-1:0] imm_val;

        assign ctl[i] = slot_ctl_t'(inst_q[i*SF +: SF]);

        vliw_operand_sel #(
            .NS (NS),
            .W  (W),
            .SW (SW)
        ) u_sel (
            .hdr_vec (s1_hdr),
            .imm_vec (s1_imm),
            .src_sel (ctl[i].src),
            .imm_sel (ctl[i].isel),
            .src_val (src_val),
            .imm_val (imm_val)
        );

        vliw_slot_alu #(
            .W (W)
        ) u_alu (
            .op      (ctl[i].op),
            .cur     (s1_hdr[i*W +: W]),
            .src_val (src_val),
            .imm_val (imm_val),
            .res     (exec_hdr[i*W +: W])
        );

        // R5: no-op and reserved codes leave the slot as it came in
        assert_slot_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (s1_valid && (ctl[i].op == OP_NOP || ctl[i].op == OP_RSV))
            |=> out_hdr[i*W +: W] == $past(s1_hdr[i*W +: W]));

        // R7: copy reads the pre-action value of the chosen slot
        assert_copy_source_R7: assert property (@(posedge clk) disable iff (rst)
            (s1_valid && ctl[i].op == OP_COPY)
            |=> out_hdr[i*W +: W] == $past(s1_hdr[ctl[i].src*W +: W]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_drop  <= 1'b0;
            out_hdr   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_drop  <= s1_valid & inst_q[DROP_BIT];
            out_hdr   <= exec_hdr;
        end
    end

    // R1: valid moves through both stages, one per cycle
    assert_fetch_flow_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);

    assert_exec_flow_R1: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    assert_no_ghost_R1: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);

    // R10: a drop is only ever flagged on a valid result
    assert_drop_gated_R10: assert property (@(posedge clk) disable iff (rst)
        out_drop |-> out_valid);

endmodule

// File: tb/sim_vliw_action_unit.sv
module sim_vliw_action_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NS    = 4;
    localparam int W     = 8;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int SW    = 2;
    localparam int SF    = 3 + 2 * SW;
    localparam int IW    = NS * SF + 1;
    localparam int HW    = NS * W;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [HW-1:0] in_hdr;
    logic          in_hit;
    logic [AW-1:0] in_act_idx;
    logic [HW-1:0] in_act_data;
    logic [AW-1:0] dflt_idx;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [IW-1:0] cfg_word;
    logic          out_valid;
    logic [HW-1:0] out_hdr;
    logic          out_drop;

    vliw_action_unit #(
        .NS    (NS),
        .W     (W),
        .DEPTH (DEPTH)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_hdr      (in_hdr),
        .in_hit      (in_hit),
        .in_act_idx  (in_act_idx),
        .in_act_data (in_act_data),
        .dflt_idx    (dflt_idx),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_word    (cfg_word),
        .out_valid   (out_valid),
        .out_hdr     (out_hdr),
        .out_drop    (out_drop)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [IW-1:0] model [DEPTH];

    // expected results; index 0 = driven last cycle, 1 = two cycles ago
    logic          h_v    [2];
    logic [HW-1:0] h_hdr  [2];
    logic          h_drop [2];
    string         h_tag  [2];

    function automatic logic [W-1:0] ref_slot(input logic [2:0] op,
        input logic [W-1:0] a, input logic [W-1:0] s, input logic [W-1:0] m);
        case (op)
            3'd1:    return m;          // R6
            3'd2:    return s;          // R7
            3'd3:    return a + m;      // R8
            3'd4:    return a - m;      // R8
            3'd5:    return a & m;      // R9
            3'd6:    return a | m;      // R9
            default: return a;          // R5
        endcase
    endfunction

    // R4: field layout used to decode a word in the reference model
    function automatic logic [HW-1:0] ref_hdr(input logic [IW-1:0] wd,
        input logic [HW-1:0] hdr, input logic [HW-1:0] ad);
        logic [HW-1:0] r;
        for (int i = 0; i < NS; i++) begin
            logic [2:0]    op;
            logic [SW-1:0] sr;
            logic [SW-1:0] ls;
            op = wd[i*SF + SF - 1 -: 3];
            sr = wd[i*SF + SW +: SW];
            ls = wd[i*SF +: SW];
            r[i*W +: W] = ref_slot(op, hdr[i*W +: W], hdr[sr*W +: W], ad[ls*W +: W]);
        end
        return r;
    endfunction

    task automatic step(input logic v, input logic [HW-1:0] hdr, input logic hit,
        input logic [AW-1:0] idx, input logic [HW-1:0] ad, input logic [AW-1:0] dfl,
        input logic we, input logic [AW-1:0] wa, input logic [IW-1:0] wd,
        input string tag);
        logic [IW-1:0] used;
        @(negedge clk);
        checks++;
        if (out_valid !== h_v[1]) begin
            fails++;
            $display("FAIL R1: out_valid got %b exp %b", out_valid, h_v[1]);
        end
        if (h_v[1]) begin
            checks++;
            if (out_hdr !== h_hdr[1]) begin
                fails++;
                $display("FAIL %s: out_hdr got %h exp %h", h_tag[1], out_hdr, h_hdr[1]);
            end
            checks++;
            if (out_drop !== h_drop[1]) begin
                fails++;
                $display("FAIL R10: out_drop got %b exp %b", out_drop, h_drop[1]);
            end
        end else begin
            checks++;
            if (out_drop !== 1'b0) begin
                fails++;
                $display("FAIL R10: out_drop got %b exp 0 on idle cycle", out_drop);
            end
        end
        // R2: hit picks the action index, miss picks the default
        used = model[hit ? idx : dfl];
        h_v[1]    = h_v[0];
        h_hdr[1]  = h_hdr[0];
        h_drop[1] = h_drop[0];
        h_tag[1]  = h_tag[0];
        h_v[0]    = v;
        h_hdr[0]  = ref_hdr(used, hdr, ad);
        h_drop[0] = v & used[IW-1];
        h_tag[0]  = tag;
        // R3: same-cycle write is not seen by this header
        if (we) model[wa] = wd;
        in_valid    = v;
        in_hdr      = hdr;
        in_hit      = hit;
        in_act_idx  = idx;
        in_act_data = ad;
        dflt_idx    = dfl;
        cfg_we      = we;
        cfg_addr    = wa;
        cfg_word    = wd;
    endtask

    function automatic string op_tag(input int op);
        case (op)
            1:       return "R6";
            2:       return "R7";
            3, 4:    return "R8";
            5, 6:    return "R9";
            default: return "R5";
        endcase
    endfunction

    logic [31:0] st = 32'h1234_5677;

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [HW-1:0] hdr;
        logic [HW-1:0] ad;
        for (int k = 0; k < DEPTH; k++) model[k] = '0;
        for (int k = 0; k < 2; k++) begin
            h_v[k] = 1'b0; h_hdr[k] = '0; h_drop[k] = 1'b0; h_tag[k] = "R1";
        end
        rst = 1'b1;
        in_valid = 1'b1; in_hdr = '1; in_hit = 1'b1; in_act_idx = '0;
        in_act_data = '1; dflt_idx = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_word = '1;

        // R11: outputs stay low throughout reset even with traffic offered
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_drop !== 1'b0) begin
                fails++;
                $display("FAIL R11: valid/drop got %b%b exp 00", out_valid, out_drop);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        rst = 1'b0;

        // R3: after reset every entry passes the header through, no drop
        for (int k = 0; k < DEPTH; k++) begin
            st = nxt(st); hdr = st; st = nxt(st); ad = st;
            step(1'b1, hdr, k[0], AW'(k), ad, AW'(DEPTH - 1 - k), 1'b0, '0, '0, "R3");
        end

        // sweep: every opcode x source selector x lane selector
        for (int c = 0; c < 128; c++) begin
            logic [IW-1:0] wd;
            int op, sr, ls;
            logic [AW-1:0] a;
            op = c >> 4; sr = (c >> 2) & 3; ls = c & 3;
            a  = AW'(c % DEPTH);
            wd = '0;
            // R4: op at field top, then source slot, then lane; drop at top bit
            for (int i = 0; i < NS; i++) begin
                wd[i*SF + SF - 1 -: 3] = 3'(op);
                wd[i*SF + SW +: SW]    = SW'((sr + i) % NS);
                wd[i*SF +: SW]         = SW'((ls + i) % NS);
            end
            wd[IW-1] = (c % 3) == 1;
            step(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, a, wd, "R3");
            for (int k = 0; k < 4; k++) begin
                st = nxt(st); hdr = st; st = nxt(st); ad = st;
                if (k == 0) begin hdr = '1; ad = 32'h0102_0301; end
                if (k == 1) begin hdr = '0; ad = 32'h0301_0201; end
                if (k == 3) begin
                    // R2: miss uses the default index; action index points away
                    step(1'b1, hdr, 1'b0, a + 3'd1, ad, a, 1'b0, '0, '0, "R2");
                end else begin
                    step(1'b1, hdr, 1'b1, a, ad, a + 3'd2, 1'b0, '0, '0, op_tag(op));
                end
            end
        end

        // R3: a write and a read of the same entry in one cycle uses the old word
        for (int k = 0; k < DEPTH; k++) begin
            logic [IW-1:0] wd;
            st = nxt(st); hdr = st; st = nxt(st); ad = st;
            st = nxt(st); wd = IW'({st, 1'b1});
            step(1'b1, hdr, 1'b1, AW'(k), ad, '0, 1'b1, AW'(k), wd, "R3");
            step(1'b1, ~hdr, 1'b1, AW'(k), ad, '0, 1'b0, '0, '0, "R3");
        end

        for (int k = 0; k < 3; k++) begin
            step(1'b0, '0, 1'b0, '0, '0, '0, 1'b0, '0, '0, "R1");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule